// File: doc/BRIEF.md
# Receiver Gain-Step Controller with Hold

This block decides when a receiver front end switches its amplifier between a high-gain and a low-gain setting. Two comparator flags from the signal-strength path feed it. One flag says the level is above an upper threshold, near -62 dBm at the antenna. The other says the level is below a lower threshold, near -70 dBm. Because the two thresholds are about 8 dB apart, the switch has hysteresis. The block drives one gain-select output. Gain is cut as soon as the upper flag is seen. It is restored only after the lower flag has stayed set for a release interval, which is counted in clock cycles (1 ms of system clock by default).

A power-enable input and a control input set the operating mode. If the control input is high when the block is powered up, switching is disabled and high gain is forced. If the control input is low, switching is automatic. While the block is powered, a rising edge on the control input freezes the gain in its present state, and bringing the control input low returns the block to automatic switching. While the block is powered down, gain is high and the control input is ignored. All four inputs pass through two-flop synchronizers before use.

Top module: `agc_lock_ctrl`

## Requirements
- R1: In automatic mode with high gain selected, an asserted upper flag sets `gain_low_o` to 1 on the third rising clock edge after the input changes (two synchronizer stages plus the state register).
- R2: In automatic mode with low gain selected, `gain_low_o` returns to 0 only after the lower flag has been seen for RELEASE_CYC consecutive synchronized cycles. This is the (RELEASE_CYC+2)-th edge after the flag rises. Any drop of the flag restarts the count, and the upper flag never releases the gain.
- R3: While `pwr_en_i` is low, the outputs are `gain_low_o`=0, `locked_o`=0 and `disabled_o`=0. Activity on `agc_ctl_i` or on the flags has no visible effect, and the mode on power-up depends only on the level of `agc_ctl_i` at that time.
- R4: Powering up with `agc_ctl_i` high sets `disabled_o`=1 three edges later and forces `gain_low_o`=0, whatever the upper flag does.
- R5: Powering up with `agc_ctl_i` low enters automatic mode with `locked_o`=0, `disabled_o`=0 and high gain.
- R6: In automatic mode, a rising edge on the synchronized `agc_ctl_i` sets `locked_o`=1 three edges after the input change. While locked, `gain_low_o` keeps its value, high or low, regardless of both flags.
- R7: Bringing `agc_ctl_i` low from the locked or disabled mode returns the block to automatic mode three edges later, and the release count starts from zero on that entry.
- R8: After reset, the outputs are `gain_low_o`=0, `locked_o`=0 and `disabled_o`=0, and the block is in the powered-down mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| above_hi_i | input | 1 | Comparator flag: level is above the upper threshold (asynchronous) |
| below_lo_i | input | 1 | Comparator flag: level is below the lower threshold (asynchronous) |
| pwr_en_i | input | 1 | Power enable; high means the receiver is powered up |
| agc_ctl_i | input | 1 | Mode control: high at power-up disables switching; a rising edge locks; low gives automatic mode |
| gain_low_o | output | 1 | 1 selects the low-gain setting |
| locked_o | output | 1 | Gain is frozen in its present state |
| disabled_o | output | 1 | Switching is disabled and high gain is forced |

## Verification
The gain path is driven with a plain upper-flag burst and with a lower flag held steady. The steady lower flag shows that the release lands on the exact edge. A lower flag that drops out partway through the interval shows that the count restarts, as opposed to accumulating. Locking is applied once in each gain state, and the flags are then driven against the lock. This separates a true freeze from a lock that only ever holds one value. Releasing the lock while the lower flag is still held checks that the count started afresh on entry. Toggling the control input while powered down, then powering up with it low and with it high, shows that only the level at power-up selects between automatic and disabled mode.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_AUTO  = 2'd1,
    MODE_HOLD  = 2'd2,
    MODE_FORCE = 2'd3
  } agc_mode_e;
endpackage

// File: rtl/agc_sync.sv
module agc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/agc_release_timer.sv
module agc_release_timer #(
  parameter int CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    done_o = run_i && (cnt_q == LAST);
    if (!run_i || done_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
    cnt_en = run_i || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/agc_mode_fsm.sv
module agc_mode_fsm
  import agc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwr_s,
  input  logic      ctl_s,
  input  logic      above_s,
  input  logic      release_i,
  output agc_mode_e mode_o,
  output logic      gain_low_o
);
  agc_mode_e mode_q, mode_d;
  logic      gain_q, gain_d;
  logic      ctl_prev_q;
  logic      ctl_rise;
  logic      st_en;

  always_comb begin
    ctl_rise = ctl_s && !ctl_prev_q;
    mode_d   = mode_q;
    gain_d   = gain_q;
    if (!pwr_s) begin
      mode_d = MODE_OFF;
      gain_d = 1'b0;
    end else begin
      unique case (mode_q)
        MODE_OFF: begin
          mode_d = ctl_s ? MODE_FORCE : MODE_AUTO;
          gain_d = 1'b0;
        end
        MODE_AUTO: begin
          if (ctl_rise)                 mode_d = MODE_HOLD;
          else if (!gain_q && above_s)  gain_d = 1'b1;
          else if (gain_q && release_i) gain_d = 1'b0;
        end
        MODE_HOLD: begin
          if (!ctl_s) mode_d = MODE_AUTO;
        end
        MODE_FORCE: begin
          gain_d = 1'b0;
          if (!ctl_s) mode_d = MODE_AUTO;
        end
        default: mode_d = MODE_OFF;
      endcase
    end
    st_en = (mode_d != mode_q) || (gain_d != gain_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      gain_q <= 1'b0;
    end else if (st_en) begin
      mode_q <= mode_d;
      gain_q <= gain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_prev_q <= 1'b0;
    else        ctl_prev_q <= ctl_s;
  end

  assign mode_o     = mode_q;
  assign gain_low_o = gain_q;
endmodule

// File: rtl/agc_lock_ctrl.sv
module agc_lock_ctrl
  import agc_pkg::*;
#(
  parameter int RELEASE_CYC = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_hi_i,
  input  logic below_lo_i,
  input  logic pwr_en_i,
  input  logic agc_ctl_i,
  output logic gain_low_o,
  output logic locked_o,
  output logic disabled_o
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, syn_in;
  logic             above_s, below_s, pwr_s, ctl_s;
  logic             timer_run, timer_done;
  logic             gain_q;
  agc_mode_e        mode_q;

  assign raw_in = {agc_ctl_i, pwr_en_i, below_lo_i, above_hi_i};

  agc_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign above_s = syn_in[0];
  assign below_s = syn_in[1];
  assign pwr_s   = syn_in[2];
  assign ctl_s   = syn_in[3];

  // count only while automatic, low gain, and below the lower threshold
  assign timer_run = (mode_q == MODE_AUTO) && gain_q && below_s;

  agc_release_timer #(.CYC(RELEASE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (timer_run),
    .done_o (timer_done)
  );

  agc_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_s      (pwr_s),
    .ctl_s      (ctl_s),
    .above_s    (above_s),
    .release_i  (timer_done),
    .mode_o     (mode_q),
    .gain_low_o (gain_q)
  );

  assign gain_low_o = gain_q;
  assign locked_o   = (mode_q == MODE_HOLD);
  assign disabled_o = (mode_q == MODE_FORCE);
endmodule

// File: rtl/agc_lock_ctrl_chk.sv
module agc_lock_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_s,
  input logic ctl_s,
  input logic above_s,
  input logic below_s,
  input logic gain_low_o,
  input logic locked_o,
  input logic disabled_o
);
  // R1
  a_r1_fast_drop: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_s && $past(pwr_s) && !ctl_s && !locked_o && !disabled_o && above_s && !gain_low_o
    |=> gain_low_o);

  // R2
  a_r2_release_needs_low_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gain_low_o) |-> ($past(below_s) || !$past(pwr_s)));

  // R3
  a_r3_off_state: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_s |=> (!gain_low_o && !locked_o && !disabled_o));

  // R4
  a_r4_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
    disabled_o |-> !gain_low_o);

  a_r4_excl_status: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked_o && disabled_o));

  // R6
  a_r6_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o && pwr_s && ctl_s |=> (locked_o && $stable(gain_low_o)));
endmodule

bind agc_lock_ctrl agc_lock_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_s      (pwr_s),
  .ctl_s      (ctl_s),
  .above_s    (above_s),
  .below_s    (below_s),
  .gain_low_o (gain_low_o),
  .locked_o   (locked_o),
  .disabled_o (disabled_o)
);

// File: tb/sim_agc_lock_ctrl.sv
module sim_agc_lock_ctrl;
  localparam int N = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above = 1'b0, below = 1'b0, pwr = 1'b0, ctl = 1'b0;
  logic gain_low, locked, disabled;

  int unsigned cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    int unsigned at;
    logic        g;
    logic        l;
    logic        d;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  agc_lock_ctrl #(.RELEASE_CYC(N)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .above_hi_i (above),
    .below_lo_i (below),
    .pwr_en_i   (pwr),
    .agc_ctl_i  (agc_ctl_wire),
    .gain_low_o (gain_low),
    .locked_o   (locked),
    .disabled_o (disabled)
  );
  logic agc_ctl_wire;
  assign agc_ctl_wire = ctl;

  // driver side: queue an expectation d cycles ahead
  task automatic expect_out(input int unsigned d, input logic g, input logic l,
                            input logic dd, input string tag);
    exp_t e;
    e.at = cyc + d; e.g = g; e.l = l; e.d = dd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at <= cyc) begin
        total++;
        if (gain_low !== q[i].g || locked !== q[i].l || disabled !== q[i].d) begin
          bad++;
          $display("FAIL %s cyc=%0d actual g/l/d=%b%b%b expected=%b%b%b",
                   q[i].tag, cyc, gain_low, locked, disabled, q[i].g, q[i].l, q[i].d);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    expect_out(1, 0, 0, 0, "R8_reset"); wait_n(3);

    // power up with control low: automatic
    pwr = 1'b1; expect_out(3, 0, 0, 0, "R5_auto_entry"); wait_n(4);
    above = 1'b1;
    expect_out(2, 0, 0, 0, "R1_not_yet");
    expect_out(3, 1, 0, 0, "R5_R1_drop"); wait_n(4);
    above = 1'b0; below = 1'b1;
    expect_out(N + 1, 1, 0, 0, "R2_hold_until_full");
    expect_out(N + 2, 0, 0, 0, "R2_release"); wait_n(N + 3);

    // interrupted release restarts the count
    below = 1'b0; above = 1'b1; wait_n(4);
    above = 1'b0; below = 1'b1; wait_n(N - 5);
    below = 1'b0; wait_n(2);
    below = 1'b1;
    expect_out(N + 1, 1, 0, 0, "R2_restart_low");
    expect_out(N + 2, 0, 0, 0, "R2_restart_release"); wait_n(N + 3);
    below = 1'b0;

    // lock in low gain, then lower flag held long
    above = 1'b1; wait_n(4); above = 1'b0;
    ctl = 1'b1; expect_out(3, 1, 1, 0, "R6_lock_low"); wait_n(4);
    below = 1'b1; expect_out(N + 4, 1, 1, 0, "R6_frozen_low"); wait_n(N + 5);

    // unlock with flag held: fresh count
    ctl = 1'b0;
    expect_out(N + 2, 1, 0, 0, "R7_fresh_count");
    expect_out(N + 3, 0, 0, 0, "R7_release_after_unlock"); wait_n(N + 4);
    below = 1'b0;

    // lock in high gain, upper flag ignored
    ctl = 1'b1; expect_out(3, 0, 1, 0, "R6_lock_high"); wait_n(4);
    above = 1'b1; expect_out(5, 0, 1, 0, "R6_frozen_high"); wait_n(6);
    above = 1'b0; ctl = 1'b0; expect_out(3, 0, 0, 0, "R7_unlock"); wait_n(4);

    // power down from low gain
    above = 1'b1; wait_n(4); above = 1'b0;
    pwr = 1'b0;
    expect_out(2, 1, 0, 0, "R3_latency");
    expect_out(3, 0, 0, 0, "R3_off_high_gain"); wait_n(4);

    // control activity while off
    above = 1'b1; ctl = 1'b1; expect_out(5, 0, 0, 0, "R3_ignored"); wait_n(3);
    ctl = 1'b0; wait_n(3); ctl = 1'b1; wait_n(3);
    ctl = 1'b0; above = 1'b0; wait_n(4);
    pwr = 1'b1; expect_out(3, 0, 0, 0, "R3_R5_power_up"); wait_n(4);
    above = 1'b1; expect_out(3, 1, 0, 0, "R3_auto_after_toggles"); wait_n(4);
    above = 1'b0;

    // power up with control high: disabled
    pwr = 1'b0; wait_n(4);
    ctl = 1'b1; wait_n(3);
    pwr = 1'b1; expect_out(3, 0, 0, 1, "R4_disabled"); wait_n(4);
    above = 1'b1; expect_out(5, 0, 0, 1, "R4_forced_high"); wait_n(6);
    above = 1'b0;

    // leave disabled mode
    ctl = 1'b0; expect_out(3, 0, 0, 0, "R7_from_disabled"); wait_n(4);
    above = 1'b1; expect_out(3, 1, 0, 0, "R7_auto_works"); wait_n(4);
    above = 1'b0; wait_n(4);

    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL R8 pending actual=%0d expected=0", q.size());
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule